// File: doc/BRIEF.md
# Floating-point invalid-operation detector

This block inspects one double-precision floating-point operation before or alongside the arithmetic datapath and decides whether the IEEE invalid-operation exception applies to it. It receives an opcode and up to two 64-bit operands, classifies each operand (zero, infinity, quiet NaN, signaling NaN, sign) and applies the rule set belonging to that opcode: addition and subtraction of infinities, zero times infinity, indeterminate quotients, square root of negative values, conversion to integer of non-finite values, and the differing NaN behaviour of ordered and unordered compares.

The decision is registered on an input valid strobe and presented one cycle later as three related indications: an invalid status flag that reports the condition regardless of trap enabling, a trap request, and a default-result request. A disable input taken from the floating-point control register steers a detected condition away from the trap and towards the default result; for every opcode except conversion the block also asks the datapath to substitute the canonical quiet NaN. Unary opcodes look at operand A only.

Top module: `fpinv_detect`

## Requirements
- R1: One cycle after a clock edge with `in_valid` high, `out_valid` is high; after an edge with `in_valid` low, `out_valid` and all flags are low. While `rst_n` is low at an edge, every output clears.
- R2: Opcode encoding: ADD=0, SUB=1, MUL=2, DIV=3, SQRT=4, CVTI=5, CMPEQ=6, CMPLT=7, CMPLE=8, CMPUN=9. Any of these with a signaling NaN (exponent bits 62:52 all ones, fraction bits 51:0 nonzero, bit 51 clear) in an examined operand raises invalid; SQRT and CVTI examine operand A only, the rest examine both.
- R3: ADD of two infinities with opposite signs (bit 63) raises invalid; SUB of two infinities with equal signs raises invalid; other infinity combinations do not.
- R4: MUL of zero by infinity, in either operand order and with any signs, raises invalid.
- R5: DIV raises invalid for zero divided by zero and for infinity divided by infinity.
- R6: SQRT raises invalid for an operand A with sign set that is neither zero nor a NaN (including negative infinity); negative zero and quiet NaNs do not raise it.
- R7: CVTI raises invalid when operand A is an infinity or any NaN.
- R8: CMPLT and CMPLE raise invalid when either operand is any NaN (quiet NaN has bit 51 set); CMPEQ and CMPUN raise it only for signaling NaNs; no compare raises it for infinities.
- R9: `inv_flag` reports the condition whatever `inv_dis` is; with `inv_dis` low a detected condition sets `trap_req` and leaves `dflt_req` low, with `inv_dis` high it sets `dflt_req` and leaves `trap_req` low.
- R10: `qnan_sub` is high exactly when `dflt_req` is high and the opcode is not CVTI.
- R11: Opcode values 10 to 15 never raise invalid, even with signaling NaN operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode (encoding in R2) |
| opnd_a | input | 64 | First operand, binary64 |
| opnd_b | input | 64 | Second operand, binary64 |
| inv_dis | input | 1 | Invalid trap disable from control register |
| out_valid | output | 1 | Registered result present |
| inv_flag | output | 1 | Invalid condition detected |
| trap_req | output | 1 | Request an invalid-operation trap |
| dflt_req | output | 1 | Request the IEEE default result instead of a trap |
| qnan_sub | output | 1 | Substitute the canonical quiet NaN |

## Verification
The only state is the single result register, so any fault in classification or in the rule table shows at the ports in the cycle right after the strobe that carried the operation: a missing or spurious `inv_flag`, or a trap and default request that disagree with `inv_dis`. A misdecoded quiet bit shows up as compare-equal or compare-unordered flagging quiet NaNs, or ordered compares missing them. A stale register shows as flags persisting into an idle cycle, which the idle checks between operations catch one cycle later.

// File: rtl/fpinv_pkg.sv
// Package: shared opcode encoding and operand class record for the
// invalid-operation detector. Assumes binary64 layout by default.
package fpinv_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int DATA_W = 1 + EXP_W + FRAC_W;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD   = 4'd0,
        OPC_SUB   = 4'd1,
        OPC_MUL   = 4'd2,
        OPC_DIV   = 4'd3,
        OPC_SQRT  = 4'd4,
        OPC_CVTI  = 4'd5,
        OPC_CMPEQ = 4'd6,
        OPC_CMPLT = 4'd7,
        OPC_CMPLE = 4'd8,
        OPC_CMPUN = 4'd9
    } opc_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic inf;
        logic nan;
        logic snan;
    } opnd_cls_t;
endpackage

// File: rtl/fpinv_classify.sv
// Module: fpinv_classify
// Sorts one floating-point operand into the classes the rule table needs.
// Assumes sign in the top bit, then exponent, then fraction; the fraction
// MSB is the quiet bit.
module fpinv_classify
    import fpinv_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] value,
    output opnd_cls_t      cls
);
    localparam int QBIT = FW - 1;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_max;
    logic          exp_min;
    logic          frac_nz;

    // Field split and exponent extremes.
    always_comb begin
        exp_f   = value[EW+FW-1:FW];
        frac_f  = value[FW-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
    end

    // Class flags derived from the fields.
    always_comb begin
        cls.neg  = value[EW+FW];
        cls.zero = exp_min & ~frac_nz;
        cls.inf  = exp_max & ~frac_nz;
        cls.nan  = exp_max & frac_nz;
        cls.snan = exp_max & frac_nz & ~frac_f[QBIT];
    end
endmodule

// File: rtl/fpinv_rules.sv
// Module: fpinv_rules
// Combinational invalid-operation decision for one opcode and two classified
// operands. Assumes unary opcodes use operand A only; unlisted opcodes never
// raise invalid.
module fpinv_rules
    import fpinv_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  opnd_cls_t       ca,
    input  opnd_cls_t       cb,
    output logic            invalid,
    output logic            is_cvt
);
    logic binary_op;
    logic snan_hit;
    logic rule_hit;
    logic known_op;

    // Operand usage and signaling-NaN screening by opcode kind.
    always_comb begin
        known_op  = (op <= OPC_CMPUN);
        binary_op = known_op && (op != OPC_SQRT) && (op != OPC_CVTI);
        snan_hit  = ca.snan | (binary_op & cb.snan);
        is_cvt    = (op == OPC_CVTI);
    end

    // Opcode-specific invalid conditions beyond signaling NaNs.
    always_comb begin
        rule_hit = 1'b0;
        case (op)
            OPC_ADD:   rule_hit = ca.inf & cb.inf & (ca.neg ^ cb.neg);
            OPC_SUB:   rule_hit = ca.inf & cb.inf & ~(ca.neg ^ cb.neg);
            OPC_MUL:   rule_hit = (ca.zero & cb.inf) | (ca.inf & cb.zero);
            OPC_DIV:   rule_hit = (ca.zero & cb.zero) | (ca.inf & cb.inf);
            OPC_SQRT:  rule_hit = ca.neg & ~ca.zero & ~ca.nan;
            OPC_CVTI:  rule_hit = ca.inf | ca.nan;
            OPC_CMPLT,
            OPC_CMPLE: rule_hit = ca.nan | cb.nan;
            default:   rule_hit = 1'b0;
        endcase
    end

    // Final decision, gated to defined opcodes.
    always_comb begin
        invalid = known_op & (snan_hit | rule_hit);
    end
endmodule

// File: rtl/fpinv_detect.sv
// Module: fpinv_detect (top)
// Classifies both operands, applies the opcode rule table and registers the
// invalid indication with its trap / default-result steering one cycle after
// in_valid. Assumes inv_dis is stable with the operation it accompanies.
module fpinv_detect
    import fpinv_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [EW+FW:0]  opnd_a,
    input  logic [EW+FW:0]  opnd_b,
    input  logic            inv_dis,
    output logic            out_valid,
    output logic            inv_flag,
    output logic            trap_req,
    output logic            dflt_req,
    output logic            qnan_sub
);
    localparam int NOPND = 2;
    localparam int DW    = EW + FW + 1;

    logic [DW-1:0] opnd_v [NOPND];
    opnd_cls_t     cls_v  [NOPND];
    logic          invalid_c;
    logic          cvt_c;

    // Gather operands into an array for the classifier generate loop.
    always_comb begin
        opnd_v[0] = opnd_a;
        opnd_v[1] = opnd_b;
    end

    for (genvar gi = 0; gi < NOPND; gi++) begin : g_cls
        fpinv_classify #(.EW(EW), .FW(FW)) u_cls (
            .value (opnd_v[gi]),
            .cls   (cls_v[gi])
        );
    end

    fpinv_rules u_rules (
        .op      (op),
        .ca      (cls_v[0]),
        .cb      (cls_v[1]),
        .invalid (invalid_c),
        .is_cvt  (cvt_c)
    );

    // Result register: capture decision on a strobe, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            inv_flag  <= 1'b0;
            trap_req  <= 1'b0;
            dflt_req  <= 1'b0;
            qnan_sub  <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            inv_flag  <= invalid_c;
            trap_req  <= invalid_c & ~inv_dis;
            dflt_req  <= invalid_c & inv_dis;
            qnan_sub  <= invalid_c & inv_dis & ~cvt_c;
        end
    end
endmodule

// File: rtl/fpinv_detect_chk.sv
// Module: fpinv_detect_chk
// Port-level temporal checks for fpinv_detect, attached through bind.
// Assumes the default binary64 layout.
module fpinv_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [63:0] opnd_a,
    input logic [63:0] opnd_b,
    input logic        inv_dis,
    input logic        out_valid,
    input logic        inv_flag,
    input logic        trap_req,
    input logic        dflt_req,
    input logic        qnan_sub
);
    logic sa, sb, unary;

    // Signaling-NaN view of the raw ports, independent of the classifier.
    always_comb begin
        sa    = (opnd_a[62:52] == 11'h7FF) && (opnd_a[51:0] != 0) && !opnd_a[51];
        sb    = (opnd_b[62:52] == 11'h7FF) && (opnd_b[51:0] != 0) && !opnd_b[51];
        unary = (op == 4'd4) || (op == 4'd5);
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_after_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid | inv_flag | trap_req | dflt_req | qnan_sub));
    p_snan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd9 && (sa || (!unary && sb))) |=> inv_flag);
    p_no_trap_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_dis) |=> !trap_req);
    p_no_dflt_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inv_dis) |=> !dflt_req);
    p_steer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_flag |-> $onehot({trap_req, dflt_req}));
    p_qnan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        qnan_sub |-> dflt_req);
    p_undef_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd9) |=> !inv_flag);
endmodule

bind fpinv_detect fpinv_detect_chk u_fpinv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .inv_dis   (inv_dis),
    .out_valid (out_valid),
    .inv_flag  (inv_flag),
    .trap_req  (trap_req),
    .dflt_req  (dflt_req),
    .qnan_sub  (qnan_sub)
);

// File: tb/test_fpinv_detect.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a reference decision written from the requirements.
module test_fpinv_detect;
    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] PONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        inv_dis = 1'b0;
    logic        out_valid, inv_flag, trap_req, dflt_req, qnan_sub;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpinv_detect i_fpinv_detect (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .inv_dis(inv_dis),
        .out_valid(out_valid), .inv_flag(inv_flag), .trap_req(trap_req),
        .dflt_req(dflt_req), .qnan_sub(qnan_sub)
    );

    function automatic bit f_nan(input logic [63:0] v);
        return v[62:52] == 11'h7FF && v[51:0] != 0;
    endfunction
    function automatic bit f_snan(input logic [63:0] v);
        return f_nan(v) && !v[51];
    endfunction
    function automatic bit f_inf(input logic [63:0] v);
        return v[62:52] == 11'h7FF && v[51:0] == 0;
    endfunction
    function automatic bit f_zero(input logic [63:0] v);
        return v[62:0] == 0;
    endfunction

    // Reference decision from R2..R8 and R11.
    function automatic bit ref_inv(input logic [3:0] o, input logic [63:0] a,
                                   input logic [63:0] b);
        bit sn;
        if (o > 4'd9) return 1'b0;
        sn = f_snan(a) || ((o != 4'd4 && o != 4'd5) && f_snan(b));
        if (sn) return 1'b1;
        case (o)
            4'd0: return f_inf(a) && f_inf(b) && a[63] != b[63];
            4'd1: return f_inf(a) && f_inf(b) && a[63] == b[63];
            4'd2: return (f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b));
            4'd3: return (f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b));
            4'd4: return a[63] && !f_zero(a) && !f_nan(a);
            4'd5: return f_inf(a) || f_nan(a);
            4'd7, 4'd8: return f_nan(a) || f_nan(b);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] rnd_opnd();
        logic [63:0] v;
        int k = $urandom_range(0, 6);
        v = {$urandom(), $urandom()};
        case (k)
            0: v[62:0] = '0;
            1: begin v[62:52] = 11'h7FF; v[51:0] = '0; end
            2: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
            3: begin v[62:52] = 11'h7FF; v[51] = 1'b0; v[0] = 1'b1; end
            4: v[62:52] = '0;
            default: if (v[62:52] == 11'h7FF) v[62] = 1'b0;
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {vld,inv,trap,dflt,qnan} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, check one cycle later.
    task automatic run_op(input string req, input logic [3:0] o, input logic [63:0] a,
                          input logic [63:0] b, input logic dis);
        bit e;
        op = o; opnd_a = a; opnd_b = b; inv_dis = dis; in_valid = 1'b1;
        @(negedge clk);
        e = ref_inv(o, a, b);
        chk(req, {out_valid, inv_flag, trap_req, dflt_req, qnan_sub},
            {1'b1, e, e & ~dis, e & dis, e & dis & (o != 4'd5)});
    endtask

    task automatic idle_chk(input string req);
        in_valid = 1'b0;
        op = 4'd5; opnd_a = SNAN; opnd_b = SNAN;
        @(negedge clk);
        chk(req, {out_valid, inv_flag, trap_req, dflt_req, qnan_sub}, 5'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset", {out_valid, inv_flag, trap_req, dflt_req, qnan_sub}, 5'b0);
        rst_n = 1'b1;
        // R1: valid then idle
        run_op("R1", 4'd0, PONE, PONE, 1'b0);
        idle_chk("R1 idle");
        // R2 signaling NaN, unary ignores B
        run_op("R2 add snan", 4'd0, PONE, SNAN, 1'b0);
        run_op("R2 sqrt b ignored", 4'd4, PONE, SNAN, 1'b0);
        run_op("R2 cmpeq snan", 4'd6, SNAN, PONE, 1'b0);
        // R3
        run_op("R3 add +inf-inf", 4'd0, PINF, NINF, 1'b0);
        run_op("R3 add +inf+inf", 4'd0, PINF, PINF, 1'b0);
        run_op("R3 sub +inf+inf", 4'd1, PINF, PINF, 1'b0);
        run_op("R3 sub -inf+inf", 4'd1, NINF, PINF, 1'b0);
        // R4
        run_op("R4 0*inf", 4'd2, NZERO, PINF, 1'b0);
        run_op("R4 inf*0", 4'd2, NINF, PZERO, 1'b0);
        // R5
        run_op("R5 0/0", 4'd3, PZERO, NZERO, 1'b0);
        run_op("R5 inf/inf", 4'd3, PINF, NINF, 1'b0);
        run_op("R5 1/0", 4'd3, PONE, PZERO, 1'b0);
        // R6
        run_op("R6 sqrt -2", 4'd4, NTWO, PONE, 1'b0);
        run_op("R6 sqrt -0", 4'd4, NZERO, PONE, 1'b0);
        run_op("R6 sqrt -inf", 4'd4, NINF, PONE, 1'b0);
        run_op("R6 sqrt -qnan", 4'd4, QNAN | NZERO, PONE, 1'b0);
        // R7
        run_op("R7 cvt inf", 4'd5, PINF, PONE, 1'b1);
        run_op("R7 cvt qnan", 4'd5, QNAN, PONE, 1'b0);
        run_op("R7 cvt one", 4'd5, PONE, PINF, 1'b0);
        // R8
        run_op("R8 cmplt qnan", 4'd7, PONE, QNAN, 1'b0);
        run_op("R8 cmple qnan", 4'd8, QNAN, PONE, 1'b0);
        run_op("R8 cmpeq qnan", 4'd6, QNAN, QNAN, 1'b0);
        run_op("R8 cmpun qnan", 4'd9, QNAN, PONE, 1'b0);
        run_op("R8 cmplt inf", 4'd7, NINF, PINF, 1'b0);
        // R9 / R10
        run_op("R9 dis add", 4'd0, PINF, NINF, 1'b1);
        run_op("R10 dis div", 4'd3, PZERO, PZERO, 1'b1);
        run_op("R10 dis cvt", 4'd5, SNAN, PONE, 1'b1);
        // R11
        run_op("R11 op10", 4'd10, SNAN, SNAN, 1'b0);
        run_op("R11 op15", 4'd15, PINF, NINF, 1'b1);
        idle_chk("R1 idle2");
        // Random mix, R2-R11
        for (int i = 0; i < 3000; i++) begin
            run_op("R2-R11 random", 4'($urandom_range(0, 11)), rnd_opnd(), rnd_opnd(),
                   1'($urandom_range(0, 1)));
            if ($urandom_range(0, 7) == 0) idle_chk("R1 random idle");
        end
        // R1 reset mid-stream
        in_valid = 1'b1; op = 4'd0; opnd_a = PINF; opnd_b = NINF;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset active", {out_valid, inv_flag, trap_req, dflt_req, qnan_sub}, 5'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule